// File: doc/BRIEF.md
# Interrupt Request Concentrator

This block folds 64 level-sensitive interrupt lines into a single outstanding vector request toward a processor. Lines 0 to 31 come from expansion-bus slots and are grouped four to a group. Each group has one mapping register. Lines 32 to 63 come from on-board devices, and each of those lines has its own mapping register. Bit 31 of a mapping register is its enable bit. The other 31 bits are a fixed, read-only identifier.

The input vector is latched on every clock. When nothing is pending, the block scans the latched lines, takes the lowest-numbered line that is asserted and enabled, and raises the matching line of its 64-line request output. That request is held until software removes it: either through a clear register, or by disabling the mapping register that owns it. Once the request is removed, the block scans again at once.

Software reaches the block through a simple 32-bit register port. Reads are combinational from the address. A write takes effect on the clock edge where `bus_wr` is high.

Top module: `irqc_top`

## Requirements
- R1: After reset every enable bit reads 0, no request is pending and `vec_req` is all zero. A reset applied while a request is pending removes it, and enables are not restored.
- R2: The live word of each mapping register is at byte address 0x004 + 8*i for group i (0..7) and 0x104 + 8*i for device i (0..31). It reads as {enable, identifier}. The identifier is 0x7C0 + 4*i for group i and 0x7E0 + i for device i. A write changes only bit 31.
- R3: A word whose address bit 2 is 0 reads as zero, and writes to it change nothing.
- R4: With no request pending, the block selects the lowest-numbered latched, asserted line whose mapping is enabled. Lines 0..31 therefore win over 32..63. A line that rises at a clock edge appears on `vec_req` after the next edge.
- R5: Only one request is outstanding. While it is pending, no other line replaces it, even a lower-numbered line.
- R6: A pending request stays in place after its source line deasserts.
- R7: Writing a mapping register with bit 31 clear removes the pending request only if that register owns it, and then rescans with the new enables. Writing any other register this way leaves the request alone.
- R8: A write to the group clear word 0x204 + 8*g removes the pending request only if it is line 4g..4g+3, and then rescans.
- R9: A write to the device clear word 0x304 + 8*i removes the pending request only if it is exactly line 32+i, and then rescans.
- R10: `vec_req` has at most one bit set, and that bit is the pending line.
- R11: One group enable bit covers four consecutive lines 4g..4g+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| irq_lvl | input | 64 | Level-sensitive interrupt lines |
| vec_req | output | 64 | One-hot vector request lines |

## Verification
The hold property assumes that only a register write can remove a pending request. It is therefore checked only on cycles where `bus_wr` is low. The stimulus keeps writes to single, isolated cycles, so holds and drops can be told apart.

The selection property assumes that the interrupt lines seen two edges earlier explain any newly raised request. The bench therefore changes `irq_lvl` only at falling edges and waits two edges before it samples.

Writes go only to the four decoded regions, so every register access stays within the documented address map.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_GRP   = 8;
    localparam int GRP_SZ    = 4;
    localparam int NUM_DEV   = 32;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;

    localparam int NUM_PCI   = NUM_GRP * GRP_SZ;
    localparam int NUM_SRC   = NUM_PCI + NUM_DEV;
    localparam int SRC_IW    = $clog2(NUM_SRC);
    localparam int REQ_W     = SRC_IW + 1;
    localparam int GRP_SHIFT = $clog2(GRP_SZ);
    localparam int GRP_IW    = $clog2(NUM_GRP);
    localparam int SLOT_IW   = $clog2(NUM_DEV);
    localparam int RO_W      = DATA_W - 1;

    localparam int LIVE_BIT  = 2;
    localparam int IDX_LSB   = 3;
    localparam int RGN_LSB   = 8;

    localparam logic [REQ_W-1:0] REQ_NONE    = REQ_W'(NUM_SRC);
    localparam logic [REQ_W-1:0] REQ_PCI_LIM = REQ_W'(NUM_PCI);
    localparam logic [RO_W-1:0]  GRP_RO_BASE = RO_W'(32'h7C0);
    localparam logic [RO_W-1:0]  DEV_RO_BASE = RO_W'(32'h7E0);

    typedef enum logic [1:0] {
        RGN_GMAP = 2'd0,
        RGN_DMAP = 2'd1,
        RGN_GCLR = 2'd2,
        RGN_DCLR = 2'd3
    } irqc_rgn_e;

    typedef struct packed {
        logic [NUM_GRP-1:0] grp_en;
        logic [NUM_DEV-1:0] dev_en;
        logic [NUM_SRC-1:0] lvl;
        logic [REQ_W-1:0]   req;
    } irqc_state_t;

    localparam irqc_state_t STATE_RST = '{
        grp_en: '0,
        dev_en: '0,
        lvl:    '0,
        req:    REQ_NONE
    };

    function automatic logic [RO_W-1:0] grp_ident(input logic [GRP_IW-1:0] i);
        return GRP_RO_BASE | (RO_W'(i) << GRP_SHIFT);
    endfunction

    function automatic logic [RO_W-1:0] dev_ident(input logic [SLOT_IW-1:0] i);
        return DEV_RO_BASE + RO_W'(i);
    endfunction

endpackage

// File: rtl/irqc_src_mask.sv
module irqc_src_mask
    import irqc_pkg::*;
(
    input  logic [NUM_GRP-1:0] grp_en,
    input  logic [NUM_DEV-1:0] dev_en,
    output logic [NUM_SRC-1:0] src_en
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i < NUM_PCI) begin : g_pci
            assign src_en[i] = grp_en[i / GRP_SZ];
        end else begin : g_dev
            assign src_en[i] = dev_en[i - NUM_PCI];
        end
    end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_vec_dec.sv
module irqc_vec_dec #(
    parameter int N  = 64,
    parameter int RW = 7
) (
    input  logic [RW-1:0] req,
    output logic [N-1:0]  vec
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign vec[i] = (req == RW'(i));
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] irq_lvl,
    output logic [NUM_SRC-1:0] vec_req
);
    irqc_state_t cur_q, nxt_d;

    logic [NUM_SRC-1:0] src_en_d;
    logic               pick_found_d;
    logic [SRC_IW-1:0]  pick_idx_d;

    irqc_rgn_e          rgn_d;
    logic [SLOT_IW-1:0] slot_d;
    logic [GRP_IW-1:0]  gslot_d;
    logic               in_map_d;
    logic               gslot_ok_d;
    logic               req_is_pci_d;
    logic               req_grp_hit_d;
    logic               req_dev_hit_d;
    logic               drop_d;
    logic [REQ_W-1:0]   req_kept_d;
    logic               unused_bits;

    assign unused_bits = ^{bus_wdata[DATA_W-2:0], bus_addr[LIVE_BIT-1:0]};

    // Address fields
    assign rgn_d      = irqc_rgn_e'(bus_addr[RGN_LSB +: 2]);
    assign slot_d     = bus_addr[IDX_LSB +: SLOT_IW];
    assign gslot_d    = slot_d[GRP_IW-1:0];
    assign gslot_ok_d = (slot_d < SLOT_IW'(NUM_GRP));
    assign in_map_d   = bus_addr[LIVE_BIT] && (bus_addr[ADDR_W-1:RGN_LSB+2] == '0);

    // Ownership of the currently pending request
    assign req_is_pci_d  = (cur_q.req < REQ_PCI_LIM);
    assign req_grp_hit_d = req_is_pci_d && gslot_ok_d
                           && (cur_q.req[GRP_SHIFT +: GRP_IW] == gslot_d);
    assign req_dev_hit_d = (cur_q.req == REQ_PCI_LIM + REQ_W'(slot_d));

    irqc_src_mask u_mask (
        .grp_en (nxt_d.grp_en),
        .dev_en (nxt_d.dev_en),
        .src_en (src_en_d)
    );

    irqc_pick #(.N(NUM_SRC), .IW(SRC_IW)) u_pick (
        .cand  (cur_q.lvl & src_en_d),
        .found (pick_found_d),
        .idx   (pick_idx_d)
    );

    irqc_vec_dec #(.N(NUM_SRC), .RW(REQ_W)) u_dec (
        .req (cur_q.req),
        .vec (vec_req)
    );

    // Next-state
    always_comb begin
        nxt_d     = cur_q;
        nxt_d.lvl = irq_lvl;
        drop_d    = 1'b0;
        if (bus_wr && in_map_d) begin
            unique case (rgn_d)
                RGN_GMAP: begin
                    if (gslot_ok_d) begin
                        nxt_d.grp_en[gslot_d] = bus_wdata[DATA_W-1];
                        if (!bus_wdata[DATA_W-1] && req_grp_hit_d) begin
                            drop_d = 1'b1;
                        end
                    end
                end
                RGN_DMAP: begin
                    nxt_d.dev_en[slot_d] = bus_wdata[DATA_W-1];
                    if (!bus_wdata[DATA_W-1] && req_dev_hit_d) begin
                        drop_d = 1'b1;
                    end
                end
                RGN_GCLR: begin
                    if (req_grp_hit_d) begin
                        drop_d = 1'b1;
                    end
                end
                RGN_DCLR: begin
                    if (req_dev_hit_d) begin
                        drop_d = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        req_kept_d = drop_d ? REQ_NONE : cur_q.req;
        if (req_kept_d == REQ_NONE && pick_found_d) begin
            nxt_d.req = REQ_W'(pick_idx_d);
        end else begin
            nxt_d.req = req_kept_d;
        end
    end

    // Register read path
    always_comb begin
        bus_rdata = '0;
        if (in_map_d) begin
            if (rgn_d == RGN_GMAP && gslot_ok_d) begin
                bus_rdata = {cur_q.grp_en[gslot_d], grp_ident(gslot_d)};
            end else if (rgn_d == RGN_DMAP) begin
                bus_rdata = {cur_q.dev_en[slot_d], dev_ident(slot_d)};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= STATE_RST;
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [11:2] addr_hi,
    input logic        wr_en_bit,
    input logic [31:0] bus_rdata,
    input logic [63:0] irq_lvl,
    input logic [63:0] vec_req
);
    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vec_req)); // R10

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req != '0 && !bus_wr) |=> (vec_req == $past(vec_req))); // R5

    AST_NEW_REQ_ASSERTED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(vec_req) == '0 && vec_req != '0) |-> ((vec_req & $past(irq_lvl, 2)) != '0)); // R4

    AST_LOW_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hi[2] |-> (bus_rdata == '0)); // R3

    AST_DEV0_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_hi == 10'h041) |-> (bus_rdata[30:0] == 31'h7E0)); // R2

    AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && addr_hi[11:8] == 4'h1 && addr_hi[2] && !wr_en_bit
         && vec_req[32 + addr_hi[7:3]])
        |=> !vec_req[32 + $past(addr_hi[7:3])]); // R7
endmodule

bind irqc_top irqc_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .addr_hi   (bus_addr[11:2]),
    .wr_en_bit (bus_wdata[31]),
    .bus_rdata (bus_rdata),
    .irq_lvl   (irq_lvl),
    .vec_req   (vec_req)
);

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] EN = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_lvl = '0;
    logic [63:0] vec_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    irqc_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_lvl   (irq_lvl),
        .vec_req   (vec_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [63:0] line(input int n);
        return 64'd1 << n;
    endfunction

    task automatic chk_vec(input string r, input logic [63:0] exp);
        checks++;
        if (vec_req !== exp) begin
            errors++;
            $display("FAIL %s vec_req actual=%h expected=%h", r, vec_req, exp);
        end
    endtask

    task automatic chk_rd(input string r, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s read[%h] actual=%h expected=%h", r, a, bus_rdata, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_irq(input int n, input logic v);
        irq_lvl[n] = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_state;
        chk_vec("R1", '0);
        chk_rd("R1", 12'h004, 32'h0000_07C0);
        chk_rd("R2", 12'h03C, 32'h0000_07DC);
        chk_rd("R2", 12'h12C, 32'h0000_07E5);
        chk_rd("R2", 12'h1FC, 32'h0000_07FF);
    endtask

    task automatic t_map_access;
        wr(12'h004, 32'hFFFF_FFFF);
        chk_rd("R2", 12'h004, 32'h8000_07C0);
        wr(12'h018, EN);
        chk_rd("R3", 12'h018, 32'h0);
        chk_rd("R3", 12'h01C, 32'h0000_07CC);
        wr(12'h004, 32'h0);
        chk_rd("R2", 12'h004, 32'h0000_07C0);
    endtask

    task automatic t_select_and_clear;
        wr(12'h00C, EN);
        wr(12'h11C, EN);
        irq_lvl[2] = 1'b1;
        irq_lvl[35] = 1'b1;
        set_irq(5, 1'b1);
        chk_vec("R4 R11", line(5));
        set_irq(4, 1'b1);
        chk_vec("R5", line(5));
        set_irq(5, 1'b0);
        chk_vec("R6", line(5));
        wr(12'h20C, 32'h0);
        chk_vec("R8 R11", line(4));
        wr(12'h204, 32'h0);
        chk_vec("R8", line(4));
        set_irq(4, 1'b0);
        wr(12'h20C, 32'h0);
        chk_vec("R4", line(35));
        wr(12'h324, 32'h0);
        chk_vec("R9", line(35));
        set_irq(35, 1'b0);
        chk_vec("R6", line(35));
        wr(12'h31C, 32'h0);
        chk_vec("R9", '0);
        set_irq(2, 1'b0);
        wr(12'h00C, 32'h0);
        wr(12'h11C, 32'h0);
    endtask

    task automatic t_disable;
        wr(12'h154, EN);
        wr(12'h1A4, EN);
        irq_lvl[52] = 1'b1;
        set_irq(42, 1'b1);
        chk_vec("R4", line(42));
        wr(12'h1A4, 32'h0);
        chk_vec("R7", line(42));
        wr(12'h154, 32'h0);
        chk_vec("R7", '0);
        wr(12'h1A4, EN);
        chk_vec("R7", line(52));
        wr(12'h014, EN);
        set_irq(9, 1'b1);
        chk_vec("R5", line(52));
        wr(12'h1A4, 32'h0);
        chk_vec("R7 R4", line(9));
        wr(12'h014, 32'h0);
        chk_vec("R7 R11", '0);
        set_irq(52, 1'b0);
    endtask

    task automatic t_reset_pending;
        wr(12'h014, EN);
        chk_vec("R4", line(9));
        rst_n = 1'b0;
        #1;
        chk_vec("R1", '0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_vec("R1", '0);
        chk_rd("R1", 12'h014, 32'h0000_07C8);
        set_irq(9, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_map_access();
        t_select_and_clear();
        t_disable();
        t_reset_pending();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule